// File: doc/BRIEF.md
# Eight-Channel Timer Register Front End

This block sits between a 32-bit memory-mapped request port and eight timer channels. It turns aligned word accesses into one-cycle write strobes for each channel's four registers, returns read data from those registers, and holds a shared control word. The channels themselves are not part of this block. The control word gives each channel four control bits. It also has a plain companion word that the block only stores and reads back.

The address window is split into two groups of channel slots. Each slot is 16 bytes. The three slots below the control slot map to channels 0 to 2. The control slot itself is at 0x30. The slots above it, from 0x40 to 0x8F, map to channels 3 to 7, so the channel number is the slot number minus one. Within a slot, bits [3:2] of the address pick the word:

| Word | Register |
|------|----------|
| 0 | count |
| 1 | reload |
| 2 | first match |
| 3 | second match |

A write to the control word starts a three-cycle sequence. First, any channel whose enable bit is being cleared is disabled. Next, the other control bits that changed are applied. Last, any channel whose enable bit is being set is enabled. While this sequence runs, the request port is held off. As a result, a channel never runs with half-updated settings.

Top module: `tmr_regif`

## Requirements
- R1: After reset:
  - the applied control bits and all strobes are zero;
  - `rsp_valid` is low;
  - `req_ready` is high;
  - the control word reads back as zero.
- R2: An accepted write to a channel slot pulses exactly bit `ch*4+word` of `ch_wr_stb` for one cycle, in the cycle after acceptance, with the write data on `ch_wdata`. Slots 0 to 2 map to channels 0 to 2; slots 4 to 8 map to channels 3 to 7.
- R3: An accepted read of a channel slot returns word `ch*4+word` of `ch_rdata` on `rsp_rdata`, in the cycle after acceptance, with the same mapping as R2.
- R4: The control word sits at 0x30. For channel `c`, the bits at `c*4` are, in order:
  - bit 0: enable;
  - bit 1: clock select;
  - bit 2: overflow interrupt;
  - bit 3: pulse mode.

  Once a control write's sequence ends, `ch_ctrl` and the read-back of 0x30 both equal the written value.
- R5: The word at 0x34 is plain 32-bit storage that reads back the last value written to it.
- R6: Pulse mode (bit 3) exists only on channels 4 to 7. A control write that sets it on channels 0 to 3 reports `rsp_err`. That pulse bit stays zero, and the rest of the write is still applied.
- R7: In the cycle after a control write is accepted, only enable bits that are being cleared change. The other changed bits change one cycle later, and never in the same cycle as an enable change.
- R8: Enable bits that are being set change two cycles after acceptance. `req_ready` is low for the two cycles after a control write is accepted.
- R9: Each bit of `ch_ctrl_stb` pulses only in the cycle its `ch_ctrl` bit changes value. A bit whose value is unchanged never strobes.
- R10: Accesses to offsets 0x38, 0x3C, or 0x90 and above report `rsp_err`. A read of such an offset returns zero, and a write to it has no effect.
- R11: A request whose address is not word aligned, or whose `req_size` is not 2 (a word), reports `rsp_err`, returns zero and has no effect.
- R12: `rsp_valid` is high in exactly the cycle after each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted; low during a control sequence |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Byte offset |
| req_size | input | 2 | Access size code; 2 = 32-bit word |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response valid |
| rsp_rdata | output | DW | Read data; zero for writes and errors |
| rsp_err | output | 1 | Access error |
| ch_wr_stb | output | NCH*4 | Per-channel, per-word write strobes |
| ch_wdata | output | DW | Data for the strobed register |
| ch_rdata | input | NCH*4*DW | Register contents from the channels, word `ch*4+word` |
| ch_ctrl | output | NCH*CB | Applied control bits |
| ch_ctrl_stb | output | NCH*CB | Change strobe for each control bit |

## Verification
The decode is exercised with reads and writes spread across both channel groups, at the first and last slots on each side of the control slot. This shows whether the slot-minus-one mapping above the hole is applied, and applied only there.

Offsets inside the hole, past the end of the map, misaligned addresses and a wrong access size are checked to show that errors suppress every strobe.

Control writes are tried in four cases, each naming which phase a bit change must land in:
- only enables set;
- a disable combined with reconfiguration;
- a re-enable combined with clearing a pulse bit;
- an illegal pulse request.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Sequencing phase of a control-word update
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_CFG  = 2'd1,
        PH_EN   = 2'd2
    } phase_e;

    // Position of each function bit inside a channel's control nibble
    localparam int CB_EN    = 0;
    localparam int CB_CLK   = 1;
    localparam int CB_OVF   = 2;
    localparam int CB_PULSE = 3;

    localparam logic [1:0] SIZE_WORD = 2'd2;

    // Result of decoding one request address
    typedef struct packed {
        logic       hit_ch;
        logic       hit_ctrl;
        logic       hit_ctrl2;
        logic       bad;
        logic [7:0] ch;
        logic [1:0] word;
    } dec_t;

    function automatic logic is_misaligned(input logic [1:0] low, input logic [1:0] size);
        return (low != 2'b00) || (size != SIZE_WORD);
    endfunction

endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
    import tmr_pkg::*;
#(
    parameter int AW        = 12,
    parameter int NCH       = 8,
    parameter int CTRL_SLOT = 3
) (
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    output dec_t          dec
);
    localparam int SW = AW - 4;

    logic [SW-1:0] slot;
    logic [1:0]    word;

    assign slot = addr[AW-1:4];
    assign word = addr[3:2];

    always_comb begin
        dec      = '0;
        dec.word = word;
        if (is_misaligned(addr[1:0], size)) begin
            dec.bad = 1'b1;
        end else if (slot < SW'(CTRL_SLOT)) begin
            dec.hit_ch = 1'b1;
            dec.ch     = 8'(slot);
        end else if (slot == SW'(CTRL_SLOT)) begin
            if (word == 2'd0)      dec.hit_ctrl  = 1'b1;
            else if (word == 2'd1) dec.hit_ctrl2 = 1'b1;
            else                   dec.bad       = 1'b1;
        end else if (slot <= SW'(NCH)) begin
            dec.hit_ch = 1'b1;
            dec.ch     = 8'(slot - SW'(1));
        end else begin
            dec.bad = 1'b1;
        end
    end

endmodule

// File: rtl/tmr_ctrl_seq.sv
module tmr_ctrl_seq
    import tmr_pkg::*;
#(
    parameter int NCH         = 8,
    parameter int CB          = 4,
    parameter int PULSE_FIRST = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic [NCH*CB-1:0] wr_data,
    output logic [NCH*CB-1:0] ctrl_q,
    output logic [NCH*CB-1:0] ctrl_stb,
    output logic              busy,
    output logic              pulse_err
);
    localparam int CW = NCH * CB;

    logic [CW-1:0] en_mask;
    logic [CW-1:0] pulse_ban;
    logic [CW-1:0] wr_clean;
    logic [CW-1:0] pend_q;
    logic [CW-1:0] dis_set, cfg_set, ena_set;
    phase_e        phase_q;

    for (genvar c = 0; c < NCH; c++) begin : g_masks
        for (genvar b = 0; b < CB; b++) begin : g_bit
            assign en_mask[c*CB+b]   = (b == CB_EN);
            assign pulse_ban[c*CB+b] = (b == CB_PULSE) && (c < PULSE_FIRST);
        end
    end

    assign wr_clean  = wr_data & ~pulse_ban;
    assign pulse_err = |(wr_data & pulse_ban);
    assign busy      = (phase_q != PH_IDLE);

    // Bits that change in each phase
    assign dis_set = ctrl_q & ~wr_clean & en_mask;
    assign cfg_set = (ctrl_q ^ pend_q) & ~en_mask;
    assign ena_set = pend_q & ~ctrl_q & en_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_IDLE;
            ctrl_q   <= '0;
            pend_q   <= '0;
            ctrl_stb <= '0;
        end else begin
            ctrl_stb <= '0;
            unique case (phase_q)
                PH_IDLE: if (go) begin
                    pend_q   <= wr_clean;
                    ctrl_q   <= ctrl_q & ~dis_set;
                    ctrl_stb <= dis_set;
                    phase_q  <= PH_CFG;
                end
                PH_CFG: begin
                    ctrl_q   <= ctrl_q ^ cfg_set;
                    ctrl_stb <= cfg_set;
                    phase_q  <= PH_EN;
                end
                PH_EN: begin
                    ctrl_q   <= ctrl_q | ena_set;
                    ctrl_stb <= ena_set;
                    phase_q  <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tmr_rd_mux.sv
module tmr_rd_mux
    import tmr_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 32,
    parameter int DW  = 32
) (
    input  dec_t                ddec,
    input  logic [NCH*4*DW-1:0] ch_rdata,
    input  logic [CW-1:0]       ctrl,
    input  logic [DW-1:0]       ctrl2,
    output logic [DW-1:0]       rdata
);
    always_comb begin
        rdata = '0;
        if (ddec.hit_ch)
            rdata = ch_rdata[(int'(ddec.ch) * 4 + int'(ddec.word)) * DW +: DW];
        else if (ddec.hit_ctrl)
            rdata = DW'(ctrl);
        else if (ddec.hit_ctrl2)
            rdata = ctrl2;
    end

endmodule

// File: rtl/tmr_regif.sv
module tmr_regif
    import tmr_pkg::*;
#(
    parameter int AW          = 12,
    parameter int DW          = 32,
    parameter int NCH         = 8,
    parameter int CB          = 4,
    parameter int CTRL_SLOT   = 3,
    parameter int PULSE_FIRST = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic                req_write,
    input  logic [AW-1:0]       req_addr,
    input  logic [1:0]          req_size,
    input  logic [DW-1:0]       req_wdata,
    output logic                rsp_valid,
    output logic [DW-1:0]       rsp_rdata,
    output logic                rsp_err,
    output logic [NCH*4-1:0]    ch_wr_stb,
    output logic [DW-1:0]       ch_wdata,
    input  logic [NCH*4*DW-1:0] ch_rdata,
    output logic [NCH*CB-1:0]   ch_ctrl,
    output logic [NCH*CB-1:0]   ch_ctrl_stb
);
    localparam int CW = NCH * CB;

    dec_t          dec;
    logic          acc, ctrl_go, busy, pulse_err;
    logic [DW-1:0] rd_word;
    logic [DW-1:0] ctrl2_q;

    tmr_decode #(.AW(AW), .NCH(NCH), .CTRL_SLOT(CTRL_SLOT)) u_dec (
        .addr (req_addr),
        .size (req_size),
        .dec  (dec)
    );

    assign req_ready = !busy;
    assign acc       = req_valid && req_ready;
    assign ctrl_go   = acc && req_write && dec.hit_ctrl;

    tmr_ctrl_seq #(.NCH(NCH), .CB(CB), .PULSE_FIRST(PULSE_FIRST)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .go        (ctrl_go),
        .wr_data   (req_wdata[CW-1:0]),
        .ctrl_q    (ch_ctrl),
        .ctrl_stb  (ch_ctrl_stb),
        .busy      (busy),
        .pulse_err (pulse_err)
    );

    tmr_rd_mux #(.NCH(NCH), .CW(CW), .DW(DW)) u_rd (
        .ddec     (dec),
        .ch_rdata (ch_rdata),
        .ctrl     (ch_ctrl),
        .ctrl2    (ctrl2_q),
        .rdata    (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
            rsp_err   <= 1'b0;
            ch_wr_stb <= '0;
            ch_wdata  <= '0;
            ctrl2_q   <= '0;
        end else begin
            rsp_valid <= acc;
            ch_wr_stb <= '0;
            if (acc) begin
                rsp_err   <= dec.bad || (ctrl_go && pulse_err);
                rsp_rdata <= req_write ? '0 : rd_word;
                if (req_write && dec.hit_ch) begin
                    ch_wr_stb[int'(dec.ch) * 4 + int'(dec.word)] <= 1'b1;
                    ch_wdata <= req_wdata;
                end
                if (req_write && dec.hit_ctrl2)
                    ctrl2_q <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/tmr_regif_chk.sv
module tmr_regif_chk #(
    parameter int AW          = 12,
    parameter int NCH         = 8,
    parameter int CB          = 4,
    parameter int PULSE_FIRST = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [AW-1:0]     req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [NCH*4-1:0]  ch_wr_stb,
    input logic [NCH*CB-1:0] ch_ctrl,
    input logic [NCH*CB-1:0] ch_ctrl_stb
);
    localparam int CW = NCH * CB;

    logic [CW-1:0] en_m, low_pulse_m;
    logic          ctrl_wr;

    for (genvar c = 0; c < NCH; c++) begin : g_m
        for (genvar b = 0; b < CB; b++) begin : g_b
            assign en_m[c*CB+b]        = (b == 0);
            assign low_pulse_m[c*CB+b] = (b == 3) && (c < PULSE_FIRST);
        end
    end

    assign ctrl_wr = req_valid && req_ready && req_write
                  && (req_addr == AW'(12'h030)) && (req_size == 2'd2);

    // R12: one response for each accepted request, one cycle later
    a_r12_rsp_follows: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> rsp_valid);
    a_r12_rsp_has_req: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && req_ready));

    // R8: port held off for two cycles after a control write
    a_r8_hold_off: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr |=> !req_ready ##1 !req_ready);

    // R2: at most one register strobe at a time
    a_r2_one_stb: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ch_wr_stb));

    // R9: strobes mark exactly the bits that changed
    a_r9_stb_is_change: assert property (@(posedge clk) disable iff (rst)
        (ch_ctrl ^ $past(ch_ctrl)) == ch_ctrl_stb);

    // R6: low channels never reach pulse mode
    a_r6_no_low_pulse: assert property (@(posedge clk) disable iff (rst)
        (ch_ctrl & low_pulse_m) == '0);

    // R7: enable changes never share a cycle with other bit changes
    a_r7_phase_split: assert property (@(posedge clk) disable iff (rst)
        !((|(ch_ctrl_stb & en_m)) && (|(ch_ctrl_stb & ~en_m))));

    // R10: an errored access strobes no channel register
    a_r10_err_quiet: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (ch_wr_stb == '0));

endmodule

bind tmr_regif tmr_regif_chk #(
    .AW(AW), .NCH(NCH), .CB(CB), .PULSE_FIRST(PULSE_FIRST)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_size    (req_size),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .ch_wr_stb   (ch_wr_stb),
    .ch_ctrl     (ch_ctrl),
    .ch_ctrl_stb (ch_ctrl_stb)
);

// File: tb/tmr_regif_test.sv
module tmr_regif_test;
    localparam int AW  = 12;
    localparam int DW  = 32;
    localparam int NCH = 8;
    localparam int CB  = 4;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                req_valid = 1'b0;
    logic                req_ready;
    logic                req_write = 1'b0;
    logic [AW-1:0]       req_addr = '0;
    logic [1:0]          req_size = 2'd2;
    logic [DW-1:0]       req_wdata = '0;
    logic                rsp_valid;
    logic [DW-1:0]       rsp_rdata;
    logic                rsp_err;
    logic [NCH*4-1:0]    ch_wr_stb;
    logic [DW-1:0]       ch_wdata;
    logic [NCH*4*DW-1:0] ch_rdata;
    logic [NCH*CB-1:0]   ch_ctrl;
    logic [NCH*CB-1:0]   ch_ctrl_stb;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    // Channel stub: each register holds a pattern naming its channel and word
    always_comb begin
        for (int c = 0; c < NCH; c++)
            for (int w = 0; w < 4; w++)
                ch_rdata[(c*4+w)*DW +: DW] = 32'hC0DE_0000 | (c << 8) | w;
    end

    tmr_regif uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .ch_wr_stb(ch_wr_stb), .ch_wdata(ch_wdata), .ch_rdata(ch_rdata),
        .ch_ctrl(ch_ctrl), .ch_ctrl_stb(ch_ctrl_stb)
    );

    typedef struct packed {
        logic        wr;
        logic [11:0] addr;
        logic [1:0]  size;
        logic [31:0] wdata;
        logic        err;
        logic [31:0] rdata;
        logic [31:0] stb;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 12'h000, 2'd2, 32'h0,         1'b0, 32'hC0DE0000, 32'h0},        // R3 ch0 w0
        '{1'b0, 12'h024, 2'd2, 32'h0,         1'b0, 32'hC0DE0201, 32'h0},        // R3 ch2 w1
        '{1'b0, 12'h04C, 2'd2, 32'h0,         1'b0, 32'hC0DE0303, 32'h0},        // R3 ch3 w3
        '{1'b0, 12'h088, 2'd2, 32'h0,         1'b0, 32'hC0DE0702, 32'h0},        // R3 ch7 w2
        '{1'b1, 12'h014, 2'd2, 32'h0000_1234, 1'b0, 32'h0,        32'h0000_0020},// R2 ch1 w1
        '{1'b1, 12'h040, 2'd2, 32'hAAAA_5555, 1'b0, 32'h0,        32'h0000_1000},// R2 ch3 w0
        '{1'b1, 12'h08C, 2'd2, 32'hFFFF_0001, 1'b0, 32'h0,        32'h8000_0000},// R2 ch7 w3
        '{1'b0, 12'h038, 2'd2, 32'h0,         1'b1, 32'h0,        32'h0},        // R10 hole
        '{1'b0, 12'h090, 2'd2, 32'h0,         1'b1, 32'h0,        32'h0},        // R10 past end
        '{1'b1, 12'h03C, 2'd2, 32'h1111_1111, 1'b1, 32'h0,        32'h0},        // R10 hole write
        '{1'b0, 12'h002, 2'd2, 32'h0,         1'b1, 32'h0,        32'h0},        // R11 misaligned
        '{1'b1, 12'h010, 2'd1, 32'h2222_2222, 1'b1, 32'h0,        32'h0},        // R11 bad size
        '{1'b1, 12'h034, 2'd2, 32'h5A5A_0FF0, 1'b0, 32'h0,        32'h0},        // R5 write
        '{1'b0, 12'h034, 2'd2, 32'h0,         1'b0, 32'h5A5A_0FF0, 32'h0}        // R5 read
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one request at a falling edge; returns at the falling edge after acceptance
    task automatic issue(input logic wr, input logic [11:0] a, input logic [1:0] sz,
                         input logic [31:0] d);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Control write, then the three sequence cycles
    task automatic ctrl_seq(input logic [31:0] d, input logic exp_err,
                            input logic [31:0] c1, input logic [31:0] s1,
                            input logic [31:0] c2, input logic [31:0] s2,
                            input logic [31:0] c3, input logic [31:0] s3);
        issue(1'b1, 12'h030, 2'd2, d);
        chk("R6 ctrl write err", 32'(rsp_err), 32'(exp_err));
        chk("R7 disable phase ctrl", ch_ctrl, c1);
        chk("R9 disable phase stb", ch_ctrl_stb, s1);
        chk("R8 busy after accept", 32'(req_ready), 32'd0);
        @(negedge clk);
        chk("R7 config phase ctrl", ch_ctrl, c2);
        chk("R9 config phase stb", ch_ctrl_stb, s2);
        chk("R8 busy in config", 32'(req_ready), 32'd0);
        chk("R12 no extra response", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk("R8 enable phase ctrl", ch_ctrl, c3);
        chk("R9 enable phase stb", ch_ctrl_stb, s3);
        chk("R8 ready after sequence", 32'(req_ready), 32'd1);
        issue(1'b0, 12'h030, 2'd2, 32'h0);
        chk("R4 ctrl readback", rsp_rdata, c3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 ready", 32'(req_ready), 32'd1);
        chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        chk("R1 ctrl", ch_ctrl, 32'h0);
        chk("R1 ctrl stb", ch_ctrl_stb, 32'h0);
        issue(1'b0, 12'h030, 2'd2, 32'h0);
        chk("R1 ctrl reads zero", rsp_rdata, 32'h0);

        for (int i = 0; i < NV; i++) begin
            issue(VECS[i].wr, VECS[i].addr, VECS[i].size, VECS[i].wdata);
            chk("R12 rsp_valid", 32'(rsp_valid), 32'd1);
            chk(VECS[i].err ? "R10/R11 err" : "R2/R3 err", 32'(rsp_err), 32'(VECS[i].err));
            chk(VECS[i].err ? "R11 rdata zero" : "R3 rdata", rsp_rdata, VECS[i].rdata);
            chk(VECS[i].err ? "R10 no strobe" : "R2 strobe", ch_wr_stb, VECS[i].stb);
            if (VECS[i].stb != 0)
                chk("R2 wdata", ch_wdata, VECS[i].wdata);
            @(negedge clk);
            chk("R2 strobe one cycle", ch_wr_stb, 32'h0);
        end

        // R4/R8: enable ch0 with overflow, ch5 with pulse
        ctrl_seq(32'h0090_0005, 1'b0,
                 32'h0000_0000, 32'h0000_0000,
                 32'h0080_0004, 32'h0080_0004,
                 32'h0090_0005, 32'h0010_0001);
        // R6: pulse on ch0 refused, nothing else changes
        ctrl_seq(32'h0090_000D, 1'b1,
                 32'h0090_0005, 32'h0,
                 32'h0090_0005, 32'h0,
                 32'h0090_0005, 32'h0);
        // R7: disable ch0 and ch5, then reconfigure ch0
        ctrl_seq(32'h0080_0002, 1'b0,
                 32'h0080_0004, 32'h0010_0001,
                 32'h0080_0002, 32'h0000_0006,
                 32'h0080_0002, 32'h0);
        // R8: clear ch5 pulse first, then re-enable ch0
        ctrl_seq(32'h0000_0003, 1'b0,
                 32'h0080_0002, 32'h0,
                 32'h0000_0002, 32'h0080_0000,
                 32'h0000_0003, 32'h0000_0001);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule